// File: doc/BRIEF.md
# Programmable Pulse-Width Modulation Generator

This block drives one pulse-width modulated output from a programmed period and a programmed first-phase duration. Every period begins with a first phase held at a selectable level, and the rest of the period holds the opposite level. When the generator is not producing periods, the output sits at a separately programmable idle level. A small register bus sets the period, the duration, a repeat count, the configuration and a free-run control bit. A start strobe launches operation, and status bits report activity and the live output level.

There are two operating modes. In one-shot mode a start produces a burst of repeat-count-plus-one periods, after which the generator returns to idle. In continuous mode periods follow one another without end. At the start of every period, the period and duration values are copied into shadow registers. The active period therefore always uses a coherent pair, and software can load the next pair at any point while the current period runs. A single-cycle event pulse serves both as the interrupt request and as the DMA synchronization request. It marks each period start in continuous mode and the end of a one-shot burst.

A start can also be made to wait for a trigger pulse from a separate edge-detecting trigger unit. An emulation-suspend input freezes the generator unless free-run is enabled.

Top module: `pwm_gen`

## Requirements
- R1: After reset the output is low, `active_o` is 0, `evt_o` is 0, and the configuration word (address 1) reads back as 0.
- R2: A period lasts the period value plus 1 cycles. Counting the first cycle of a period as cycle 0, the output holds the first-phase level in cycles below the duration value and the opposite level in the remaining cycles.
- R3: A duration of 0 drives the opposite level for the whole period. A duration at or above period+1, up to all ones, drives the first-phase level for the whole period.
- R4: The configuration word has these fields: mode in bits 1:0 (0 off, 1 one-shot, 2 continuous, 3 treated as off), trigger select in bits 3:2 (0 means no trigger), first-phase level in bit 4, idle level in bit 5 and event enable in bit 6. In one-shot mode, a start produces exactly repeat+1 periods. The first cycle after the start strobe is cycle 0. After the last period the output returns to the idle level and `active_o` drops.
- R5: A start strobe that arrives while the generator is active has no effect on the waveform or on the burst length.
- R6: In continuous mode, new period and duration values written during a period take effect from the next period start and not before.
- R7: If the mode is switched from continuous to one-shot while running, the current period completes. The generator then runs repeat+1 further periods and stops with an end event, without a new start. No event marks the starts of those further periods.
- R8: Writing mode 0 forces the output to the idle level in the first cycle after the write, and `active_o` drops one cycle later. Setting a running mode again does not restart the generator without a start strobe, and a start strobe under mode 3 starts nothing.
- R9: `evt_o` is a one-cycle pulse, and only when the event enable bit is 1. In continuous mode it is high in cycle 0 of every period. In one-shot mode it is high in the first idle cycle after a burst.
- R10: When the free-run bit (address 0, bit 0) is 0 and `susp_i` is high, the count holds and the output stays frozen, so the waveform resumes later by the number of suspended cycles. When the free-run bit is 1, `susp_i` has no effect.
- R11: With a nonzero trigger select, a start strobe arms the generator: `active_o` goes high while the output stays idle. The first period begins in the cycle after a `trig_i` pulse. `trig_i` pulses during a burst or while idle are ignored.
- R12: Reading the configuration word returns the active flag in bit 17 and the current output level in bit 16. Register addresses: 0 control, 1 configuration, 2 repeat, 3 period, 4 duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | ADDR_W | Register address for write and read |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data (combinational on addr_i) |
| start_i | input | 1 | Start strobe, one cycle |
| trig_i | input | 1 | Trigger pulse from the trigger unit |
| susp_i | input | 1 | Emulation suspend |
| pwm_o | output | 1 | Modulated output |
| evt_o | output | 1 | Interrupt / DMA event pulse |
| active_o | output | 1 | Generator armed or running |
| lvl_o | output | 1 | Current output level |

## Verification
The bench builds the block with its defaults: 32-bit counters, an 8-bit repeat count and a 32-bit data bus. At this width, an all-ones duration checks that the full-period compare still holds when the duration is far above period+1. Small programmed periods of four to ten cycles keep each burst, each continuous reload and the continuous-to-one-shot hand-over within a few dozen cycles. Each of these sequences is then compared sample by sample against closed-form cycle counts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_CONT = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  // bit 6 ien, 5 inact, 4 p1, 3:2 trig, 1:0 mode
  typedef struct packed {
    logic       ien;
    logic       inact;
    logic       p1;
    logic [1:0] trig;
    mode_e      mode;
  } cfg_t;

  localparam int unsigned CFG_W   = $bits(cfg_t);
  localparam int unsigned ACT_BIT = 17;
  localparam int unsigned LVL_BIT = 16;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_RPT  = 3'd2;
  localparam logic [2:0] A_PER  = 3'd3;
  localparam logic [2:0] A_DUR  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } st_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned RPT_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  input  logic              lvl_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o,
  output logic              free_o,
  output logic [RPT_W-1:0]  rpt_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  dur_o
);

  cfg_t             cfg_q;
  logic             free_q;
  logic [RPT_W-1:0] rpt_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] dur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      free_q <= 1'b0;
      rpt_q  <= '0;
      per_q  <= '0;
      dur_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(A_CTRL): free_q <= wdata_i[0];
        ADDR_W'(A_CFG):  cfg_q  <= cfg_t'(wdata_i[CFG_W-1:0]);
        ADDR_W'(A_RPT):  rpt_q  <= wdata_i[RPT_W-1:0];
        ADDR_W'(A_PER):  per_q  <= wdata_i[CNT_W-1:0];
        ADDR_W'(A_DUR):  dur_q  <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CTRL): rdata_o[0] = free_q;
      ADDR_W'(A_CFG): begin
        rdata_o[CFG_W-1:0] = cfg_q;
        rdata_o[ACT_BIT]   = active_i;
        rdata_o[LVL_BIT]   = lvl_i;
      end
      ADDR_W'(A_RPT): rdata_o[RPT_W-1:0] = rpt_q;
      ADDR_W'(A_PER): rdata_o[CNT_W-1:0] = per_q;
      ADDR_W'(A_DUR): rdata_o[CNT_W-1:0] = dur_q;
      default: ;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign free_o = free_q;
  assign rpt_o  = rpt_q;
  assign per_o  = per_q;
  assign dur_o  = dur_q;

endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned RPT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             free_i,
  input  logic [RPT_W-1:0] rpt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic             susp_i,
  output logic             pwm_o,
  output logic             evt_o,
  output logic             active_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [RPT_W-1:0] RPT_ONE = RPT_W'(1);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q, per_q, dur_q;
  logic [RPT_W-1:0] rpt_q;
  logic             burst_q, seen_q, evt_q, susp_q, frz_q;

  logic mode_act, susp_act, trig_en, live, pwm_run, launch, stop;

  assign mode_act = (cfg_i.mode == MODE_ONE) || (cfg_i.mode == MODE_CONT);
  assign susp_act = susp_i && !free_i;
  assign trig_en  = cfg_i.trig != 2'b00;
  assign live     = (cnt_q < dur_q) ? cfg_i.p1 : !cfg_i.p1;
  assign pwm_run  = (st_q == ST_RUN) ? live : cfg_i.inact;
  assign pwm_o    = !mode_act ? cfg_i.inact : (susp_q ? frz_q : pwm_run);
  assign active_o = st_q != ST_IDLE;
  assign evt_o    = evt_q;

  always_comb begin
    launch = 1'b0;
    stop   = 1'b0;
    case (st_q)
      ST_IDLE: launch = start_i && !trig_en;
      ST_ARM:  launch = !susp_act && (trig_i || seen_q);
      ST_RUN: begin
        if (!susp_act && cnt_q == per_q) begin
          if (cfg_i.mode == MODE_ONE && burst_q && rpt_q == '0) stop = 1'b1;
          else                                                  launch = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
      dur_q   <= '0;
      rpt_q   <= '0;
      burst_q <= 1'b0;
      seen_q  <= 1'b0;
      evt_q   <= 1'b0;
      susp_q  <= 1'b0;
      frz_q   <= 1'b0;
    end else begin
      evt_q  <= 1'b0;
      susp_q <= susp_act;
      if (susp_act && !susp_q) frz_q <= pwm_o;
      if (!mode_act) begin
        st_q    <= ST_IDLE;
        burst_q <= 1'b0;
        seen_q  <= 1'b0;
      end else if (launch) begin
        // shadow copy at every period start
        st_q   <= ST_RUN;
        cnt_q  <= '0;
        per_q  <= per_i;
        dur_q  <= dur_i;
        seen_q <= 1'b0;
        if (cfg_i.mode == MODE_CONT) begin
          burst_q <= 1'b0;
          rpt_q   <= rpt_i;
          evt_q   <= cfg_i.ien && !susp_act;
        end else if (burst_q && st_q == ST_RUN) begin
          rpt_q <= rpt_q - RPT_ONE;
        end else begin
          burst_q <= 1'b1;
          rpt_q   <= rpt_i;
        end
      end else if (stop) begin
        st_q    <= ST_IDLE;
        burst_q <= 1'b0;
        evt_q   <= cfg_i.ien;
      end else begin
        if (st_q == ST_IDLE && start_i && trig_en) begin
          st_q   <= ST_ARM;
          seen_q <= 1'b0;
        end
        if (st_q == ST_ARM && susp_act && trig_i) seen_q <= 1'b1;
        if (st_q == ST_RUN && !susp_act) cnt_q <= cnt_q + CNT_ONE;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> (cnt_q <= per_q)); // R2

  AST_IDLE_INACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !susp_q) |-> (pwm_o == cfg_i.inact)); // R4

  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_act |=> !active_o); // R8

  AST_EVT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(cfg_i.ien)); // R9

  AST_SUSP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && $past(susp_q) && mode_act && $past(mode_act)) |-> $stable(pwm_o)); // R10

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned RPT_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic              susp_i,
  output logic              pwm_o,
  output logic              evt_o,
  output logic              active_o,
  output logic              lvl_o
);

  cfg_t             cfg;
  logic             free;
  logic [RPT_W-1:0] rpt;
  logic [CNT_W-1:0] per, dur;

  pwm_regs #(
    .CNT_W (CNT_W),
    .RPT_W (RPT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .active_i(active_o),
    .lvl_i   (pwm_o),
    .rdata_o (rdata_o),
    .cfg_o   (cfg),
    .free_o  (free),
    .rpt_o   (rpt),
    .per_o   (per),
    .dur_o   (dur)
  );

  pwm_core #(
    .CNT_W(CNT_W),
    .RPT_W(RPT_W)
  ) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg),
    .free_i  (free),
    .rpt_i   (rpt),
    .per_i   (per),
    .dur_i   (dur),
    .start_i (start_i),
    .trig_i  (trig_i),
    .susp_i  (susp_i),
    .pwm_o   (pwm_o),
    .evt_o   (evt_o),
    .active_o(active_o)
  );

  assign lvl_o = pwm_o;

endmodule

// File: tb/test_pwm_gen.sv
`timescale 1ns/1ps
module test_pwm_gen;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        start_i = 1'b0, trig_i = 1'b0, susp_i = 1'b0;
  logic        pwm_o, evt_o, active_o, lvl_o;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] CTRL = 3'd0, CFG = 3'd1, RPT = 3'd2, PER = 3'd3, DUR = 3'd4;

  always #2.5 clk_i = ~clk_i;

  pwm_gen i_pwm_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .start_i(start_i), .trig_i(trig_i), .susp_i(susp_i),
    .pwm_o(pwm_o), .evt_o(evt_o), .active_o(active_o), .lvl_o(lvl_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(input logic ien, input logic inact, input logic p1,
                                       input logic [1:0] trig, input logic [1:0] mode);
    return {25'd0, ien, inact, p1, trig, mode};
  endfunction

  function automatic logic lv(input longint c, input longint d, input logic p1);
    return (c < d) ? p1 : !p1;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    addr_i = CFG;
    #1;
    chk("R1 pwm", pwm_o, 0);
    chk("R1 active", active_o, 0);
    chk("R1 evt", evt_o, 0);
    chk("R1 cfg read", rdata_o, 0);
  endtask

  task automatic t_oneshot();
    wr(RPT, 2); wr(PER, 4); wr(DUR, 2); wr(CFG, cfgw(1, 0, 1, 0, 1));
    pulse_start();
    for (int k = 0; k < 18; k++) begin
      if (k < 15) begin
        chk($sformatf("R2 wave k=%0d", k), pwm_o, lv(k % 5, 2, 1));
        chk("R4 active in burst", active_o, 1);
      end else begin
        chk($sformatf("R4 idle k=%0d", k), pwm_o, 0);
        chk("R4 active after burst", active_o, 0);
      end
      chk($sformatf("R9 end evt k=%0d", k), evt_o, k == 15);
      @(negedge clk_i);
    end
  endtask

  task automatic edge_case(input logic [31:0] d, input logic p1);
    wr(RPT, 0); wr(PER, 3); wr(DUR, d); wr(CFG, cfgw(0, 0, p1, 0, 1));
    pulse_start();
    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R3 dur=%0h k=%0d", d, k), pwm_o, (k < 4) ? lv(k, longint'(d), p1) : 1'b0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_edges();
    edge_case(32'd0, 1'b0);
    edge_case(32'd4, 1'b1);
    edge_case(32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_restart();
    wr(RPT, 1); wr(PER, 3); wr(DUR, 1); wr(CFG, cfgw(0, 0, 1, 0, 1));
    pulse_start();
    for (int k = 0; k < 11; k++) begin
      chk($sformatf("R5 wave k=%0d", k), pwm_o, (k < 8) ? lv(k % 4, 1, 1) : 1'b0);
      chk($sformatf("R5 active k=%0d", k), active_o, k < 8);
      chk("R9 no evt when disabled", evt_o, 0);
      start_i = (k == 2);
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  task automatic t_cont();
    wr(RPT, 0); wr(PER, 7); wr(DUR, 3); wr(CFG, cfgw(1, 0, 1, 0, 2));
    pulse_start();
    for (int k = 0; k < 31; k++) begin
      int c, d;
      c = (k < 8) ? k : (k - 8) % 10;
      d = (k < 8) ? 3 : 5;
      chk($sformatf("R6 wave k=%0d", k), pwm_o, lv(c, d, 1));
      chk($sformatf("R9 period evt k=%0d", k), evt_o, k == 0 || k == 8 || k == 18 || k == 28);
      if (k == 5 || k == 9) begin
        chk("R12 active bit", rdata_o[17], 1);
        chk("R12 level bit", rdata_o[16], pwm_o);
      end
      we_i = 1'b0;
      if (k == 2) begin we_i = 1'b1; addr_i = PER; wdata_i = 9; end
      if (k == 3) begin we_i = 1'b1; addr_i = DUR; wdata_i = 5; end
      if (k == 4) addr_i = CFG;
      @(negedge clk_i);
    end
    we_i = 1'b0;
    wr(CFG, cfgw(1, 0, 1, 0, 0));
    @(negedge clk_i);
  endtask

  task automatic t_graceful();
    wr(RPT, 1); wr(PER, 7); wr(DUR, 3); wr(CFG, cfgw(1, 0, 1, 0, 2));
    pulse_start();
    for (int k = 0; k < 28; k++) begin
      chk($sformatf("R7 wave k=%0d", k), pwm_o, (k < 24) ? lv(k % 8, 3, 1) : 1'b0);
      chk($sformatf("R7 active k=%0d", k), active_o, k < 24);
      chk($sformatf("R7 evt k=%0d", k), evt_o, k == 0 || k == 24);
      we_i = 1'b0;
      if (k == 2) begin we_i = 1'b1; addr_i = CFG; wdata_i = cfgw(1, 0, 1, 0, 1); end
      @(negedge clk_i);
    end
    we_i = 1'b0;
  endtask

  task automatic t_disable();
    wr(RPT, 0); wr(PER, 7); wr(DUR, 3); wr(CFG, cfgw(0, 1, 1, 0, 2));
    pulse_start();
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R8 wave k=%0d", k), pwm_o, (k <= 3) ? lv(k, 3, 1) : 1'b1);
      chk($sformatf("R8 active k=%0d", k), active_o, k <= 4);
      we_i = 1'b0;
      if (k == 3) begin we_i = 1'b1; addr_i = CFG; wdata_i = cfgw(0, 1, 1, 0, 0); end
      @(negedge clk_i);
    end
    we_i = 1'b0;
    wr(CFG, cfgw(0, 1, 1, 0, 2));
    for (int k = 0; k < 4; k++) begin
      chk("R8 no restart active", active_o, 0);
      chk("R8 no restart pwm", pwm_o, 1);
      @(negedge clk_i);
    end
    wr(CFG, cfgw(0, 1, 1, 0, 3));
    pulse_start();
    for (int k = 0; k < 4; k++) begin
      chk("R8 reserved active", active_o, 0);
      chk("R8 reserved pwm", pwm_o, 1);
      @(negedge clk_i);
    end
    wr(CFG, cfgw(0, 0, 1, 0, 0));
  endtask

  task automatic t_susp(input logic free);
    int stop_k;
    stop_k = free ? 6 : 10;
    wr(CTRL, {31'd0, free}); wr(RPT, 0); wr(PER, 5); wr(DUR, 3); wr(CFG, cfgw(1, 0, 1, 0, 1));
    pulse_start();
    for (int k = 0; k < 14; k++) begin
      int c;
      if (free) c = k;
      else      c = (k <= 1) ? k : ((k <= 5) ? 1 : k - 4);
      chk($sformatf("R10 free=%0d wave k=%0d", free, k), pwm_o, (k < stop_k) ? lv(c, 3, 1) : 1'b0);
      chk($sformatf("R10 free=%0d evt k=%0d", free, k), evt_o, k == stop_k);
      if (k == 1) susp_i = 1'b1;
      if (k == 5) susp_i = 1'b0;
      @(negedge clk_i);
    end
    susp_i = 1'b0;
    wr(CTRL, 0);
  endtask

  task automatic t_trig();
    wr(RPT, 0); wr(PER, 3); wr(DUR, 1); wr(CFG, cfgw(0, 0, 1, 2'd1, 1));
    pulse_start();
    for (int j = 0; j < 4; j++) begin
      chk("R11 armed active", active_o, 1);
      chk("R11 armed pwm idle", pwm_o, 0);
      @(negedge clk_i);
    end
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    for (int k = 0; k < 9; k++) begin
      chk($sformatf("R11 wave k=%0d", k), pwm_o, (k < 4) ? lv(k, 1, 1) : 1'b0);
      chk($sformatf("R11 active k=%0d", k), active_o, k < 4);
      trig_i = (k == 1) || (k == 5);
      @(negedge clk_i);
    end
    trig_i = 1'b0;
    wr(CFG, cfgw(0, 0, 1, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_oneshot();
    t_edges();
    t_restart();
    t_cont();
    t_graceful();
    t_disable();
    t_susp(1'b0);
    t_susp(1'b1);
    t_trig();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog all requirements act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule